// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the per-pixel-clock timing of a progressive-scan display: horizontal sync, vertical sync, a data-enable strobe, the current pixel column and line, and an RGB value for pixels the block colours itself. Software sets the timing through a small write-only register bus. Each axis is described by an active length plus three blanking intervals, and the porches and sync width of an axis are packed into one 32-bit word.

A mode register picks one of three behaviours. Off holds the raster idle. Normal output runs the raster and fills active pixels with a background colour wherever no plane data is valid. The colour-bar mode runs the raster and paints eight vertical bars across the active width. Timing values are copied into shadow copies only at a frame boundary, or at any time while the block is off. A frame therefore never mixes two timings.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the mode is off, hsync and vsync are high (inactive, active-low default), de is 0, x, y and rgb are 0, and the background colour is 0x7F7F7F.
- R2: Each line starts with the active pixels (de high when the line is active), followed by the front porch, then hsync asserted for the sync width, then the back porch. The line period equals the sum of the four intervals.
- R3: Lines follow the same order vertically. vsync is asserted for whole lines, from line active+front to line active+front+sync-1. The frame period in lines is the sum of the four vertical intervals. de is high only on active lines.
- R4: While de is high, x is the pixel index within the line and y is the line index. Both are 0 while de is low.
- R5: Register addresses: 0 mode, 1 horizontal timing, 2 vertical timing, 3 active size, 4 background, 5 polarity. Writes to 6 and 7 are ignored. In a timing word, bits 31:22 are the back porch, bits 21:11 the sync width and bits 10:0 the front porch. In the size word, bits 31:16 are the active lines and bits 15:0 the active pixels per line, with the low ACT_W bits used. An 800x480 mode with porches 42/128/86 (front/sync/back) and 10/2/33 gives a 1056-cycle line with a 128-cycle hsync pulse.
- R6: Mode 1, 2 and 3 all give normal output. Mode 4 gives colour bars. Mode 0 and the unused values 5 to 7 are off.
- R7: In off mode the counters are held at 0, de is 0 and both syncs sit at their inactive level. On leaving off mode, the first cycle is pixel 0 of line 0.
- R8: In colour-bar mode, bar k (k = 0..7) covers pixels k*W to (k+1)*W-1, where W is the active width divided by 8 (rounded down). Pixels past 8*W stay in bar 7. The colours in bar order are FFFFFF, FFFF00, 00FFFF, 00FF00, FF00FF, FF0000, 0000FF, 000000.
- R9: In normal mode, rgb equals the background register during active pixels with plane_valid low. rgb is 0 when plane_valid is high or de is low. Background writes take effect at once.
- R10: Polarity register bit 0 set makes hsync active-high and bit 1 set makes vsync active-high. A cleared bit gives active-low. Polarity writes take effect at once.
- R11: A timing or size write made while the raster runs takes effect at the start of the next frame. The current frame completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| plane_valid | input | 1 | Plane data present for the current pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-pixel strobe |
| x | output | ACT_W | Pixel column during de |
| y | output | ACT_W | Line index during de |
| rgb | output | 24 | Bar or background colour |

## Verification
A reference model runs every cycle alongside the design. It checks all six outputs under a compact timing with unequal porches and sync widths, so a swapped interval order or swapped field position shows up as a shifted edge. The same raster is then run as colour bars, with both polarities, and with modes 2, 3 and 5. A timing write in the middle of a frame tells a frame-boundary update apart from an immediate one. Switching off in the middle of a line checks that the counters restart at the origin. A final run of several full 800-pixel lines confirms the packed field decode at realistic values.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int FIELD_W  = 11;
   localparam int BP_LSB   = 22;
   localparam int SW_LSB   = 11;
   localparam int FP_LSB   = 0;
   localparam int LINES_LSB = 16;
   localparam int ADDR_W   = 3;
   localparam int NUM_BARS = 8;
   localparam int BAR_IDX_W = $clog2(NUM_BARS);

   localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
   localparam logic [ADDR_W-1:0] A_HTIM = 3'd1;
   localparam logic [ADDR_W-1:0] A_VTIM = 3'd2;
   localparam logic [ADDR_W-1:0] A_SIZE = 3'd3;
   localparam logic [ADDR_W-1:0] A_BGND = 3'd4;
   localparam logic [ADDR_W-1:0] A_POL  = 3'd5;

   typedef enum logic [1:0] {PATH_OFF, PATH_NORMAL, PATH_BARS} path_e;

   typedef struct packed {
      logic [FIELD_W-1:0] bp;
      logic [FIELD_W-1:0] sw;
      logic [FIELD_W-1:0] fp;
   } porch_t;

   function automatic path_e decode_mode(input logic [2:0] m);
      case (m)
         3'd1, 3'd2, 3'd3: return PATH_NORMAL;
         3'd4:             return PATH_BARS;
         default:          return PATH_OFF;
      endcase
   endfunction

   function automatic porch_t unpack_porch(input logic [31:0] w);
      porch_t p;
      p.bp = FIELD_W'(w[31:BP_LSB]);
      p.sw = w[SW_LSB +: FIELD_W];
      p.fp = w[FP_LSB +: FIELD_W];
      return p;
   endfunction
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
   import rtg_pkg::*;
#(
   parameter int ACT_W = 12,
   parameter int H_ACT = 800,
   parameter int H_FP  = 42,
   parameter int H_SW  = 128,
   parameter int H_BP  = 86,
   parameter int V_ACT = 480,
   parameter int V_FP  = 10,
   parameter int V_SW  = 2,
   parameter int V_BP  = 33,
   parameter logic [23:0] BG_RESET = 24'h7F7F7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              load_shadow,
   output path_e             path,
   output logic              pol_h,
   output logic              pol_v,
   output logic [23:0]       bg,
   output porch_t            sh_h,
   output porch_t            sh_v,
   output logic [ACT_W-1:0]  sh_hact,
   output logic [ACT_W-1:0]  sh_vact
);
   localparam porch_t H_RST = '{bp: FIELD_W'(H_BP), sw: FIELD_W'(H_SW), fp: FIELD_W'(H_FP)};
   localparam porch_t V_RST = '{bp: FIELD_W'(V_BP), sw: FIELD_W'(V_SW), fp: FIELD_W'(V_FP)};

   logic [2:0]       mode_q;
   porch_t           h_live, v_live;
   logic [ACT_W-1:0] hact_live, vact_live;
   logic [1:0]       pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 3'd0;
         h_live    <= H_RST;
         v_live    <= V_RST;
         hact_live <= ACT_W'(H_ACT);
         vact_live <= ACT_W'(V_ACT);
         bg        <= BG_RESET;
         pol_q     <= 2'b00;
      end else if (cfg_we) begin
         case (cfg_addr)
            A_MODE: mode_q <= cfg_wdata[2:0];
            A_HTIM: h_live <= unpack_porch(cfg_wdata);
            A_VTIM: v_live <= unpack_porch(cfg_wdata);
            A_SIZE: begin
               hact_live <= cfg_wdata[0 +: ACT_W];
               vact_live <= cfg_wdata[LINES_LSB +: ACT_W];
            end
            A_BGND: bg    <= cfg_wdata[23:0];
            A_POL:  pol_q <= cfg_wdata[1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_h    <= H_RST;
         sh_v    <= V_RST;
         sh_hact <= ACT_W'(H_ACT);
         sh_vact <= ACT_W'(V_ACT);
      end else if (load_shadow) begin
         sh_h    <= h_live;
         sh_v    <= v_live;
         sh_hact <= hact_live;
         sh_vact <= vact_live;
      end
   end

   assign path  = decode_mode(mode_q);
   assign pol_h = pol_q[0];
   assign pol_v = pol_q[1];

   // R11: shadow timing moves only on a load request
   a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_shadow |=> ($stable(sh_h) && $stable(sh_v) && $stable(sh_hact) && $stable(sh_vact)));
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
   import rtg_pkg::*;
#(
   parameter int ACT_W = 12,
   parameter int TOT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [ACT_W-1:0] act,
   input  porch_t           porch,
   output logic [ACT_W-1:0] pos,
   output logic             last,
   output logic             in_act,
   output logic             in_sync
);
   logic [TOT_W-1:0] cnt, total, sync_lo, sync_hi;

   assign sync_lo = TOT_W'(act) + TOT_W'(porch.fp);
   assign sync_hi = sync_lo + TOT_W'(porch.sw);
   assign total   = sync_hi + TOT_W'(porch.bp);

   assign last    = (cnt == total - 1'b1);
   assign in_act  = (cnt < TOT_W'(act));
   assign in_sync = (cnt >= sync_lo) && (cnt < sync_hi);
   assign pos     = cnt[ACT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (step)  cnt <= last ? '0 : cnt + 1'b1;
   end

   // R3: counter holds between steps
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !step) |=> $stable(cnt));
   // R2: wrap to the origin after the last position
   a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && step && last) |=> (cnt == '0));
   // R2: counter stays inside the period
   a_r2_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && total != '0) |-> (cnt < total));
endmodule

// File: rtl/rtg_pixel.sv
module rtg_pixel
   import rtg_pkg::*;
#(
   parameter int ACT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  path_e            path,
   input  logic             pol_h,
   input  logic             pol_v,
   input  logic [23:0]      bg,
   input  logic             plane_valid,
   input  logic [ACT_W-1:0] bar_w,
   input  logic [ACT_W-1:0] hpos,
   input  logic [ACT_W-1:0] vpos,
   input  logic             h_last,
   input  logic             h_in_act,
   input  logic             v_in_act,
   input  logic             h_in_sync,
   input  logic             v_in_sync,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [ACT_W-1:0] x,
   output logic [ACT_W-1:0] y,
   output logic [23:0]      rgb
);
   localparam logic [BAR_IDX_W-1:0] LAST_BAR = BAR_IDX_W'(NUM_BARS - 1);

   logic                 run, hs, vs;
   logic [ACT_W-1:0]     bar_pos;
   logic [BAR_IDX_W-1:0] bar_idx;
   logic [23:0]          bar_tab [NUM_BARS];

   for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      localparam logic [2:0] IDX = 3'(b);
      assign bar_tab[b] = {{8{~IDX[1]}}, {8{~IDX[2]}}, {8{~IDX[0]}}};
   end

   assign run = (path != PATH_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bar_pos <= '0;
         bar_idx <= '0;
      end else if (!run || h_last) begin
         bar_pos <= '0;
         bar_idx <= '0;
      end else if (bar_pos == bar_w - 1'b1 && bar_idx != LAST_BAR) begin
         bar_pos <= '0;
         bar_idx <= bar_idx + 1'b1;
      end else begin
         bar_pos <= bar_pos + 1'b1;
      end
   end

   assign hs    = run & h_in_sync;
   assign vs    = run & v_in_sync;
   assign hsync = pol_h ? hs : ~hs;
   assign vsync = pol_v ? vs : ~vs;
   assign de    = run & h_in_act & v_in_act;
   assign x     = de ? hpos : '0;
   assign y     = de ? vpos : '0;

   always_comb begin
      rgb = 24'h0;
      if (de) begin
         case (path)
            PATH_BARS:   rgb = bar_tab[bar_idx];
            PATH_NORMAL: rgb = plane_valid ? 24'h0 : bg;
            default:     rgb = 24'h0;
         endcase
      end
   end

   // R8: bars advance by at most one within a line
   a_r8_bar_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !h_last) |=> (bar_idx == $past(bar_idx) || bar_idx == $past(bar_idx) + 1'b1));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int ACT_W = 12,
   parameter int H_ACT = 800,
   parameter int H_FP  = 42,
   parameter int H_SW  = 128,
   parameter int H_BP  = 86,
   parameter int V_ACT = 480,
   parameter int V_FP  = 10,
   parameter int V_SW  = 2,
   parameter int V_BP  = 33,
   parameter logic [23:0] BG_RESET = 24'h7F7F7F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [31:0]      cfg_wdata,
   input  logic             plane_valid,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [ACT_W-1:0] x,
   output logic [ACT_W-1:0] y,
   output logic [23:0]      rgb
);
   localparam int WIDE_W = (ACT_W > FIELD_W) ? ACT_W : FIELD_W;
   localparam int TOT_W  = WIDE_W + 2;

   if (ACT_W < 4 || ACT_W > 16) begin : g_bad_width
      $error("ACT_W must lie in 4..16");
   end
   if (H_ACT >= (1 << ACT_W) || V_ACT >= (1 << ACT_W)) begin : g_bad_default
      $error("default active size does not fit ACT_W");
   end

   path_e            path;
   logic             pol_h, pol_v, load_shadow, run;
   logic [23:0]      bg;
   porch_t           sh_h, sh_v;
   logic [ACT_W-1:0] sh_hact, sh_vact, hpos, vpos, bar_w;
   logic             h_last, v_last, h_in_act, v_in_act, h_in_sync, v_in_sync;

   assign run         = (path != PATH_OFF);
   assign load_shadow = !run || (h_last && v_last);
   assign bar_w       = sh_hact >> BAR_IDX_W;

   rtg_cfg_regs #(
      .ACT_W(ACT_W), .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
      .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP), .BG_RESET(BG_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .load_shadow(load_shadow), .path(path),
      .pol_h(pol_h), .pol_v(pol_v), .bg(bg), .sh_h(sh_h), .sh_v(sh_v),
      .sh_hact(sh_hact), .sh_vact(sh_vact)
   );

   rtg_axis #(.ACT_W(ACT_W), .TOT_W(TOT_W)) u_hax (
      .clk(clk), .rst_n(rst_n), .clear(!run), .step(1'b1), .act(sh_hact),
      .porch(sh_h), .pos(hpos), .last(h_last), .in_act(h_in_act), .in_sync(h_in_sync)
   );

   rtg_axis #(.ACT_W(ACT_W), .TOT_W(TOT_W)) u_vax (
      .clk(clk), .rst_n(rst_n), .clear(!run), .step(h_last), .act(sh_vact),
      .porch(sh_v), .pos(vpos), .last(v_last), .in_act(v_in_act), .in_sync(v_in_sync)
   );

   rtg_pixel #(.ACT_W(ACT_W)) u_pix (
      .clk(clk), .rst_n(rst_n), .path(path), .pol_h(pol_h), .pol_v(pol_v),
      .bg(bg), .plane_valid(plane_valid), .bar_w(bar_w), .hpos(hpos), .vpos(vpos),
      .h_last(h_last), .h_in_act(h_in_act), .v_in_act(v_in_act),
      .h_in_sync(h_in_sync), .v_in_sync(v_in_sync), .hsync(hsync), .vsync(vsync),
      .de(de), .x(x), .y(y), .rgb(rgb)
   );

   // R7: an off cycle leaves the raster at its origin
   a_r7_origin_after_off: assert property (@(posedge clk) disable iff (!rst_n)
      (path == PATH_OFF) |=> (x == '0 && y == '0));
   // R4: reported column stays inside the active width
   a_r4_x_in_active: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (x < sh_hact));
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
   localparam int ACT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [2:0]       cfg_addr = 3'd0;
   logic [31:0]      cfg_wdata = 32'd0;
   logic             plane_valid = 1'b0;
   logic             hsync, vsync, de;
   logic [ACT_W-1:0] x, y;
   logic [23:0]      rgb;

   int n_chk = 0, n_fail = 0, n_tick = 0;
   bit done = 1'b0;
   string ovr = "";

   // reference state
   int mh = 0, mv = 0, mmode = 0, mpol = 0, mbg = 'h7F7F7F;
   int c_ha = 800, c_hf = 42, c_hs = 128, c_hb = 86, c_va = 480, c_vf = 10, c_vs = 2, c_vb = 33;
   int l_ha = 800, l_hf = 42, l_hs = 128, l_hb = 86, l_va = 480, l_vf = 10, l_vs = 2, l_vb = 33;

   always #10 clk = ~clk;

   raster_timing_gen dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .plane_valid(plane_valid), .hsync(hsync),
      .vsync(vsync), .de(de), .x(x), .y(y), .rgb(rgb)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, n_tick);
      end
   endtask

   function automatic logic [23:0] bar_colour(input int k);
      case (k)
         0: return 24'hFFFFFF;
         1: return 24'hFFFF00;
         2: return 24'h00FFFF;
         3: return 24'h00FF00;
         4: return 24'hFF00FF;
         5: return 24'hFF0000;
         6: return 24'h0000FF;
         default: return 24'h000000;
      endcase
   endfunction

   function automatic bit running(input int m);
      return (m >= 1 && m <= 4);
   endfunction

   // compare outputs against the model, then advance the model through the next edge
   task automatic tick();
      bit run, e_de, hs, vs;
      int e_x, e_y, w, k;
      logic [23:0] e_rgb;
      plane_valid = (n_tick % 3 == 0);
      #1;
      run  = running(mmode);
      e_de = run && mh < c_ha && mv < c_va;
      hs   = run && mh >= c_ha + c_hf && mh < c_ha + c_hf + c_hs;
      vs   = run && mv >= c_va + c_vf && mv < c_va + c_vf + c_vs;
      e_x  = e_de ? mh : 0;
      e_y  = e_de ? mv : 0;
      e_rgb = 24'h0;
      if (e_de && mmode == 4) begin
         w = c_ha / 8;
         k = (w == 0) ? 0 : mh / w;
         if (k > 7) k = 7;
         e_rgb = bar_colour(k);
      end else if (e_de) begin
         e_rgb = plane_valid ? 24'h0 : 24'(mbg);
      end
      chk(hsync == ((mpol & 1) ? hs : !hs), (ovr != "") ? ovr : "R2", "hsync", 32'(hsync), 32'((mpol & 1) ? hs : !hs));
      chk(vsync == ((mpol & 2) ? vs : !vs), (ovr != "") ? ovr : "R3", "vsync", 32'(vsync), 32'((mpol & 2) ? vs : !vs));
      chk(de == e_de, (ovr != "") ? ovr : "R2", "de", 32'(de), 32'(e_de));
      chk(32'(x) == e_x && 32'(y) == e_y, (ovr != "") ? ovr : "R4", "x/y",
          {4'h0, x, 4'h0, y}, {4'h0, 12'(e_x), 4'h0, 12'(e_y)});
      chk(rgb == e_rgb, (ovr != "") ? ovr : ((mmode == 4) ? "R8" : "R9"), "rgb", 32'(rgb), 32'(e_rgb));
      // model edge
      if (!run) begin
         mh = 0; mv = 0;
         c_ha = l_ha; c_hf = l_hf; c_hs = l_hs; c_hb = l_hb;
         c_va = l_va; c_vf = l_vf; c_vs = l_vs; c_vb = l_vb;
      end else if (mh == c_ha + c_hf + c_hs + c_hb - 1) begin
         mh = 0;
         if (mv == c_va + c_vf + c_vs + c_vb - 1) begin
            mv = 0;
            c_ha = l_ha; c_hf = l_hf; c_hs = l_hs; c_hb = l_hb;
            c_va = l_va; c_vf = l_vf; c_vs = l_vs; c_vb = l_vb;
         end else mv++;
      end else mh++;
      if (cfg_we) begin
         case (cfg_addr)
            3'd0: mmode = int'(cfg_wdata[2:0]);
            3'd1: begin l_hb = int'(cfg_wdata[31:22]); l_hs = int'(cfg_wdata[21:11]); l_hf = int'(cfg_wdata[10:0]); end
            3'd2: begin l_vb = int'(cfg_wdata[31:22]); l_vs = int'(cfg_wdata[21:11]); l_vf = int'(cfg_wdata[10:0]); end
            3'd3: begin l_ha = int'(cfg_wdata[11:0]); l_va = int'(cfg_wdata[27:16]); end
            3'd4: mbg = int'(cfg_wdata[23:0]);
            3'd5: mpol = int'(cfg_wdata[1:0]);
            default: ;
         endcase
      end
      n_tick++;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic run_n(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic t_reset();
      ovr = "R1";
      chk(hsync == 1'b1 && vsync == 1'b1, "R1", "syncs idle", {hsync, vsync}, 2'b11);
      chk(de == 1'b0 && rgb == 24'h0 && x == '0 && y == '0, "R1", "data idle", {de, rgb}, 0);
      run_n(5);
      ovr = "";
   endtask

   task automatic t_small_raster();
      ovr = "R5";
      wr(3'd1, (32'd4 << 22) | (32'd3 << 11) | 32'd2);
      wr(3'd2, (32'd1 << 22) | (32'd2 << 11) | 32'd1);
      wr(3'd3, (32'd4 << 16) | 32'd16);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'h1234_5678);
      ovr = "";
      wr(3'd0, 32'd1);          // R2 R3 R4 R9 with default background
      run_n(400);
      wr(3'd4, 32'h00_12AB34);  // R9 new background at once
      run_n(60);
   endtask

   task automatic t_bars();
      wr(3'd0, 32'd4);          // R8
      run_n(420);
   endtask

   task automatic t_polarity();
      ovr = "R10";
      wr(3'd5, 32'd3);
      run_n(220);
      wr(3'd5, 32'd1);
      run_n(220);
      wr(3'd5, 32'd0);
      ovr = "";
   endtask

   task automatic t_midframe_change();
      ovr = "R11";
      wr(3'd0, 32'd1);
      run_n(57);
      wr(3'd1, (32'd2 << 22) | (32'd5 << 11) | 32'd3);
      wr(3'd3, (32'd3 << 16) | 32'd24);
      run_n(450);
      ovr = "";
   endtask

   task automatic t_modes();
      ovr = "R6";
      wr(3'd0, 32'd2); run_n(40);
      wr(3'd0, 32'd3); run_n(40);
      wr(3'd0, 32'd5); run_n(30);
      wr(3'd0, 32'd7); run_n(10);
      ovr = "R7";
      wr(3'd0, 32'd1); run_n(33);
      wr(3'd0, 32'd0); run_n(20);
      wr(3'd0, 32'd1); run_n(60);
      ovr = "";
   endtask

   task automatic t_wide_mode();
      ovr = "R5";
      wr(3'd0, 32'd0);
      wr(3'd1, (32'd86 << 22) | (32'd128 << 11) | 32'd42);
      wr(3'd2, (32'd33 << 22) | (32'd2 << 11) | 32'd10);
      wr(3'd3, (32'd480 << 16) | 32'd800);
      wr(3'd0, 32'd1);
      run_n(3 * 1056 + 5);
      ovr = "";
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_small_raster();
      t_bars();
      t_polarity();
      t_midframe_change();
      t_modes();
      t_wide_mode();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=done", n_tick);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule